// File: doc/BRIEF.md
# Host Register Access Port with Single-Word DMA Buffer

This block is the slave end of a strobe-based synchronous processor bus. The host opens each access with one cycle in which chip select is low and the address strobe is high, and the address is latched on that cycle. In the next cycle the host lowers write enable to store its data word into the register addressed, or lowers output enable to read that register. The read word goes onto the host data bus through a tri-state driver. The driver is enabled combinationally while chip select and output enable are both low. The register file holds a parameterised number of general-purpose words. Reads of addresses above the file return zero, and writes to those addresses are dropped.

A single DMA data register links the host bus to the chip interior in both directions. When the register is empty, the block raises a DMA write request. The host answers with an active-low write acknowledge, and the word on the host bus is stored. That word then leaves on a valid/ready output stream, and it stays there until the consumer takes it. An input stream can instead fill the empty register. This raises a DMA read request, and the request stays up until the host's active-low read acknowledge is sampled. While the read acknowledge is low, the register's word is the one the host data bus carries. Both streams follow the usual rules. A word moves only on a clock edge where valid and ready are both high. A source holding valid must keep its data stable. `in_ready` drops in any cycle where the host write acknowledge is low.

Top module: `host_reg_slave`

## Requirements
- R1: The address bus is captured only on a rising edge where `ale` is 1 and `cs_n` is 0. A strobe with `cs_n` at 1 leaves the latched address unchanged. Later reads and writes use the latched address.
- R2: If `we_n` and `cs_n` are both 0 in the cycle right after a capture cycle, the register at the latched address takes `data_in` on that edge.
- R3: A write enable that does not come in the cycle right after a capture cycle changes no register.
- R4: `data_oe` is 1 exactly when `cs_n` and `oe_n` are both 0, with no clock delay. While `data_oe` is 0, `data_out` is zero.
- R5: With `dack_rd_n` at 1 and `data_oe` at 1, `data_out` carries the register at the latched address. Addresses 16 to 31 (at default sizes) read as zero, and writes to them change nothing.
- R6: After reset every register reads zero, the DMA buffer is empty, `dma_wr_req` is 1, and `dma_rd_req` and `out_valid` are 0.
- R7: `dma_wr_req` stays 1 while the buffer is empty until `dack_wr_n` is sampled 0. On that edge `data_in` is stored, the request drops, and `out_valid` rises with the stored word on `out_data`.
- R8: With the buffer empty and `dack_wr_n` at 1, `in_ready` is 1. An accepted input word raises `dma_rd_req`, which holds until `dack_rd_n` is sampled 0 and the buffer empties. While `dack_rd_n` is 0 and `data_oe` is 1, `data_out` carries the buffer word.
- R9: `out_valid` and `out_data` hold steady until `out_ready` is sampled 1, and the buffer then empties. If `dack_wr_n` is 0 in the same cycle as `in_valid`, the host write wins and `in_ready` is 0.
- R10: An acknowledge arriving while its own request is low does not change the buffer word or its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| ale | input | 1 | Address strobe, active high, one cycle |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Register address |
| data_in | input | DATA_W | Host data bus, inbound half |
| data_out | output | DATA_W | Host data bus, outbound half |
| data_oe | output | 1 | Tri-state driver enable for the host bus |
| dma_wr_req | output | 1 | DMA write request, host to buffer |
| dack_wr_n | input | 1 | DMA write acknowledge, active low |
| dma_rd_req | output | 1 | DMA read request, buffer to host |
| dack_rd_n | input | 1 | DMA read acknowledge, active low |
| out_valid | output | 1 | Output stream valid |
| out_ready | input | 1 | Output stream ready |
| out_data | output | DATA_W | Output stream word |
| in_valid | input | 1 | Input stream valid |
| in_ready | output | 1 | Input stream ready |
| in_data | input | DATA_W | Input stream word |

## Verification
Register access is driven in four patterns. Properly framed writes followed by reads show whether the latched address and the write strobe line up. A strobe given with chip select high shows whether capture is gated by chip select. A write enable delayed by one idle cycle shows whether a stale strobe is rejected. Accesses above the file show the zero fill for unused addresses. The DMA side is run through a host write held back by a stalled consumer, an input word drained by the host read acknowledge, acknowledges given while their request is low, and a host acknowledge that collides with input valid. Together these separate correct request holding, priority and back-pressure from loose versions of each. A behavioural model in the bench compares every output on every clock.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    DMA_EMPTY   = 2'd0,
    DMA_WR_FULL = 2'd1,
    DMA_RD_PEND = 2'd2
  } dma_state_e;
endpackage

// File: rtl/hb_addr_latch.sv
module hb_addr_latch #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ale,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] addr_q,
  output logic              wr_fire
);
  logic capture;
  logic armed_q;

  assign capture = ale & ~cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= capture;
      if (capture) addr_q <= addr;
    end
  end

  // write is honoured only in the cycle right after a capture
  assign wr_fire = armed_q & ~cs_n & ~we_n;

  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && !cs_n) |=> (addr_q == $past(addr)));
  p_no_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale && !cs_n) |=> $stable(addr_q));
  p_stale_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> $past(ale && !cs_n));
endmodule

// File: rtl/hb_regfile.sv
module hb_regfile #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5,
  parameter int NUM_REGS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [NUM_REGS-1:0][DATA_W-1:0] regs_flat;
  logic wr_in_range;
  logic rd_in_range;

  assign wr_in_range = (int'(wr_addr) < NUM_REGS);
  assign rd_in_range = (int'(rd_addr) < NUM_REGS);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic hit;
    assign hit = wr_fire & wr_in_range & (int'(wr_addr) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wr_data;
    end
    assign regs_flat[g] = q;
  end

  assign rd_data = rd_in_range ? regs_flat[rd_addr[IDX_W-1:0]] : '0;

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(regs_flat));
  p_unimpl_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !wr_in_range) |=> $stable(regs_flat));
endmodule

// File: rtl/hb_dma_buf.sv
module hb_dma_buf
  import hb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dack_wr_n,
  input  logic              dack_rd_n,
  input  logic [DATA_W-1:0] host_data,
  output logic              dma_wr_req,
  output logic              dma_rd_req,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] buf_data
);
  dma_state_e state_q, state_d;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    state_d = state_q;
    data_d  = data_q;
    unique case (state_q)
      DMA_EMPTY: begin
        if (!dack_wr_n) begin
          data_d  = host_data;
          state_d = DMA_WR_FULL;
        end else if (in_valid) begin
          data_d  = in_data;
          state_d = DMA_RD_PEND;
        end
      end
      DMA_WR_FULL: if (out_ready) state_d = DMA_EMPTY;
      DMA_RD_PEND: if (!dack_rd_n) state_d = DMA_EMPTY;
      default:     state_d = DMA_EMPTY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DMA_EMPTY;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      data_q  <= data_d;
    end
  end

  assign dma_wr_req = (state_q == DMA_EMPTY);
  assign dma_rd_req = (state_q == DMA_RD_PEND);
  assign out_valid  = (state_q == DMA_WR_FULL);
  assign in_ready   = (state_q == DMA_EMPTY) & dack_wr_n;
  assign out_data   = data_q;
  assign buf_data   = data_q;

  p_wrreq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_wr_req && dack_wr_n && !in_valid) |=> dma_wr_req);
  p_wr_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_wr_req && !dack_wr_n) |=> (out_valid && out_data == $past(host_data)));
  p_rdreq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_rd_req && dack_rd_n) |=> dma_rd_req);
  p_out_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  p_ack_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_wr_req && !dack_wr_n && dack_rd_n) |=> $stable(buf_data));
  p_one_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({dma_wr_req, dma_rd_req, out_valid}));
endmodule

// File: rtl/host_reg_slave.sv
module host_reg_slave
  import hb_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5,
  parameter int NUM_REGS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ale,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              dma_wr_req,
  input  logic              dack_wr_n,
  output logic              dma_rd_req,
  input  logic              dack_rd_n,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data
);
  logic [ADDR_W-1:0] addr_q;
  logic              wr_fire;
  logic [DATA_W-1:0] reg_rd;
  logic [DATA_W-1:0] buf_data;
  logic [DATA_W-1:0] bus_sel;

  hb_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ale(ale), .we_n(we_n),
    .addr(addr), .addr_q(addr_q), .wr_fire(wr_fire)
  );

  hb_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(addr_q),
    .wr_data(data_in), .rd_addr(addr_q), .rd_data(reg_rd)
  );

  hb_dma_buf #(.DATA_W(DATA_W)) u_dma (
    .clk(clk), .rst_n(rst_n), .dack_wr_n(dack_wr_n), .dack_rd_n(dack_rd_n),
    .host_data(data_in), .dma_wr_req(dma_wr_req), .dma_rd_req(dma_rd_req),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .buf_data(buf_data)
  );

  // bus gating is purely combinational
  assign data_oe  = ~cs_n & ~oe_n;
  assign bus_sel  = dack_rd_n ? reg_rd : buf_data;
  assign data_out = data_oe ? bus_sel : '0;

  p_quiet_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_out == '0));
  p_dma_read_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && !dack_rd_n) |-> (data_out == out_data));
endmodule

// File: tb/host_reg_slave_tb_top.sv
`timescale 1ns/1ps
module host_reg_slave_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, ale = 1'b0, we_n = 1'b1, oe_n = 1'b1;
  logic [4:0]  addr = '0;
  logic [31:0] data_in = '0, in_data = '0;
  logic        dack_wr_n = 1'b1, dack_rd_n = 1'b1, out_ready = 1'b0, in_valid = 1'b0;
  logic [31:0] data_out, out_data;
  logic        data_oe, dma_wr_req, dma_rd_req, out_valid, in_ready;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string reg_tag = "R6", dma_tag = "R6";

  always #4 clk = ~clk;

  host_reg_slave dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ale(ale), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .dma_wr_req(dma_wr_req), .dack_wr_n(dack_wr_n), .dma_rd_req(dma_rd_req),
    .dack_rd_n(dack_rd_n), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data)
  );

  // behavioural reference
  logic [31:0] m_regs [16];
  logic [4:0]  m_addr;
  bit          m_armed;
  int          m_st;      // 0 empty, 1 holding host word, 2 waiting for host read
  logic [31:0] m_buf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_regs[i]) m_regs[i] = '0;
      m_addr = '0; m_armed = 0; m_st = 0; m_buf = '0;
    end else begin
      if (m_armed && !cs_n && !we_n && m_addr < 16) m_regs[m_addr[3:0]] = data_in;
      m_armed = ale && !cs_n;
      if (ale && !cs_n) m_addr = addr;
      case (m_st)
        0: if (!dack_wr_n) begin m_buf = data_in; m_st = 1; end
           else if (in_valid) begin m_buf = in_data; m_st = 2; end
        1: if (out_ready) m_st = 0;
        default: if (!dack_rd_n) m_st = 0;
      endcase
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #3;
    if (!done) begin
      logic oe_exp;
      logic [31:0] bus_exp;
      oe_exp  = !cs_n && !oe_n;
      bus_exp = !oe_exp ? 32'h0 : (!dack_rd_n ? m_buf : (m_addr < 16 ? m_regs[m_addr[3:0]] : 32'h0));
      chk("R4", "data_oe", {31'h0, data_oe}, {31'h0, oe_exp});
      chk(!dack_rd_n ? "R8" : reg_tag, "data_out", data_out, bus_exp);
      chk(dma_tag, "dma_wr_req", {31'h0, dma_wr_req}, {31'h0, m_st == 0});
      chk(dma_tag, "dma_rd_req", {31'h0, dma_rd_req}, {31'h0, m_st == 2});
      chk(dma_tag, "out_valid", {31'h0, out_valid}, {31'h0, m_st == 1});
      chk("R9", "in_ready", {31'h0, in_ready}, {31'h0, m_st == 0 && dack_wr_n});
      if (m_st == 1) chk(dma_tag, "out_data", out_data, m_buf);
    end
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      cs_n = 1; ale = 0; we_n = 1; oe_n = 1;
    end
  endtask

  task automatic host_write(logic [4:0] a, logic [31:0] d);
    @(negedge clk); cs_n = 0; ale = 1; addr = a;
    @(negedge clk); ale = 0; we_n = 0; data_in = d;
    @(negedge clk); we_n = 1; cs_n = 1;
  endtask

  task automatic host_read(logic [4:0] a);
    @(negedge clk); cs_n = 0; ale = 1; addr = a;
    @(negedge clk); ale = 0; oe_n = 0;
    @(negedge clk); oe_n = 1; cs_n = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2);
    host_read(5'd3);                 // R6: reset contents

    reg_tag = "R2"; dma_tag = "R7";
    host_write(5'd0, 32'hA5A5_0001);
    host_write(5'd7, 32'h1234_5678);
    host_write(5'd15, 32'hFFFF_0000);
    host_read(5'd0); host_read(5'd7); host_read(5'd15);
    for (int i = 0; i < 16; i++) host_write(i[4:0], 32'hC0DE_0000 + i);
    for (int i = 0; i < 16; i++) host_read(i[4:0]);

    reg_tag = "R1";                  // strobe with chip select high
    host_read(5'd4);
    @(negedge clk); cs_n = 1; ale = 1; addr = 5'd9;
    @(negedge clk); ale = 0; cs_n = 0; oe_n = 0;
    @(negedge clk); oe_n = 1; cs_n = 1;
    @(negedge clk); cs_n = 1; ale = 1; addr = 5'd9;
    @(negedge clk); ale = 0; cs_n = 0; we_n = 0; data_in = 32'hBAD0_0009;
    @(negedge clk); we_n = 1; cs_n = 1;
    host_read(5'd4); host_read(5'd9);

    reg_tag = "R3";                  // late write enable
    @(negedge clk); cs_n = 0; ale = 1; addr = 5'd2;
    @(negedge clk); ale = 0;
    @(negedge clk); we_n = 0; data_in = 32'hDEAD_BEEF;
    @(negedge clk); we_n = 1; cs_n = 1;
    host_read(5'd2);

    reg_tag = "R4";
    @(negedge clk); cs_n = 1; oe_n = 0;
    @(negedge clk); cs_n = 0; oe_n = 1;
    @(negedge clk); cs_n = 0; oe_n = 0;
    idle(1);

    reg_tag = "R5";
    host_write(5'd20, 32'h5555_AAAA);
    host_read(5'd20); host_read(5'd31); host_read(5'd4);

    dma_tag = "R7";                  // host write into buffer, consumer stalled
    @(negedge clk); dack_wr_n = 0; data_in = 32'h0DA7_A001;
    @(negedge clk); dack_wr_n = 1; data_in = 32'h0;
    dma_tag = "R9";
    idle(3);
    dma_tag = "R10";
    @(negedge clk); dack_wr_n = 0; data_in = 32'h7777_7777;
    @(negedge clk); dack_wr_n = 1; dack_rd_n = 0;
    @(negedge clk); dack_rd_n = 1;
    dma_tag = "R9";
    @(negedge clk); out_ready = 1;
    @(negedge clk); out_ready = 0;
    idle(2);

    dma_tag = "R8";                  // stream word out to host
    @(negedge clk); in_valid = 1; in_data = 32'hFEED_0042;
    @(negedge clk); in_valid = 0;
    idle(3);
    dma_tag = "R10";
    @(negedge clk); dack_wr_n = 0; data_in = 32'h1111_2222;
    @(negedge clk); dack_wr_n = 1;
    dma_tag = "R8";
    @(negedge clk); cs_n = 0; oe_n = 0; dack_rd_n = 0;
    @(negedge clk); cs_n = 1; oe_n = 1; dack_rd_n = 1;
    idle(2);

    dma_tag = "R9";                  // collision: host ack wins
    @(negedge clk); in_valid = 1; in_data = 32'h0BAD_0BAD; dack_wr_n = 0; data_in = 32'h600D_600D;
    @(negedge clk); dack_wr_n = 1; in_valid = 0;
    idle(2);
    @(negedge clk); out_ready = 1;
    @(negedge clk); out_ready = 0;
    idle(3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule